// File: doc/BRIEF.md
# Flash Page Erase and Word Program Sequencer

This block sequences page erase and word programming of an on-chip flash array from a small byte-wide register interface. Software first loads a word address with two byte writes and can set a timeout limit. It then sets a control bit to start either a page erase, a write, or an erase followed by a write. During a write, software streams bytes into a data register. Each pair of bytes is packed into one 16-bit word and programmed at the current address. The address then advances by one for the next pair.

A write has no word count. It ends when the between-word timer expires. If the timer expires with half a byte pair received, the write is reported as failed through a sticky flag. Two flags report progress to software. An overall busy flag stays set for the whole operation. A per-word busy flag is set while the array is working on an erase or a word, and software waits for it to clear before it sends the next pair. The array itself sits behind a simple request/done handshake.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, busy_o, sw_busy_o and failed_o are low and addr_o is zero.
- R2: Register select codes are 0 for control (bit 0 requests erase, bit 1 requests write), 1 for address bits [7:0], 2 for address bits [13:8] (taken from data bits [5:0]), 3 for data bytes and 4 for the timeout limit. Writes to the control, address and limit registers are ignored while busy_o is high.
- R3: A control write with only the write bit set starts a write without erasing. In a write, the first data byte becomes word bits [7:0] and the second becomes bits [15:8], and the word is programmed at addr_o.
- R4: After each word is programmed, addr_o increases by one, so consecutive pairs land at n, n+1, n+2 and so on.
- R5: sw_busy_o is high in the cycles during which a page erase or a word program is in progress. It is high at the first sample after the second byte of a pair. busy_o is high from the accepted start until the operation ends.
- R6: A control write with only the erase bit set erases the page addressed by address bits [13:9]. Every word in that page then reads 0xFFFF, and busy_o falls when the erase completes.
- R7: When erase and write are requested together, the page erase is issued to the array before any word program.
- R8: The collection timer restarts whenever collection starts (after the start command, after the erase, or after each word). A write ends at the limit+1-th clock edge after that start unless a byte pair completes first.
- R9: If the timer expires while a byte pair is half received, failed_o is set. failed_o stays set until the next accepted start command clears it. A timer expiry at a pair boundary leaves failed_o low.
- R10: Data-register writes are ignored unless a write is collecting bytes. Stray bytes sent while idle do not shift the pairing of a later write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select code |
| reg_wdata_i | input | 8 | Register write data |
| busy_o | output | 1 | Operation in progress |
| sw_busy_o | output | 1 | Erase or word program in progress |
| failed_o | output | 1 | Sticky write-abort flag |
| addr_o | output | 14 | Current word address |
| fl_prog_o | output | 1 | Word program request to the array |
| fl_erase_o | output | 1 | Page erase request to the array |
| fl_addr_o | output | 14 | Array word address (page base during erase) |
| fl_wdata_o | output | 16 | Word to program |
| fl_done_i | input | 1 | Array completion pulse |

## Verification
Single-word writes are driven from a table, with and without a preceding erase, into erased cells, already programmed cells and cells that were never erased. The resulting words show whether an erase was really issued, whether the bytes landed in the right halves, and whether the word reached the correct address. A multi-word stream, with control and address writes injected mid-stream, separates correct auto-increment from reloading or restarting. Timeout runs are sampled on the exact cycle where busy should drop, with and without a half pair pending, which tells a clean end apart from an abort and an off-by-one window. A stray idle byte followed by a fresh write exposes pairing state that leaks across operations.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ERASE,
    ST_COLLECT,
    ST_PROG
  } fp_state_e;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_ADDRL = 3'd1;
  localparam logic [2:0] SEL_ADDRH = 3'd2;
  localparam logic [2:0] SEL_DATA  = 3'd3;
  localparam logic [2:0] SEL_TMO   = 3'd4;

  localparam int CTRL_ERASE_BIT = 0;
  localparam int CTRL_WRITE_BIT = 1;
endpackage

// File: rtl/flash_addr_ctr.sv
module flash_addr_ctr #(
  parameter int ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_lo_i,
  input  logic              we_hi_i,
  input  logic [7:0]        wdata_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (inc_i) begin
      addr_q <= addr_q + 1'b1;
    end else begin
      if (we_lo_i) addr_q[7:0]        <= wdata_i;
      if (we_hi_i) addr_q[ADDR_W-1:8] <= wdata_i[HI_W-1:0];
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/flash_byte_pack.sv
module flash_byte_pack #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              byte_we_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              half_o,
  output logic              word_vld_o,
  output logic [2*BYTE_W-1:0] word_o
);
  logic [BYTE_W-1:0] lo_q;
  logic              half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      half_q <= 1'b0;
    end else if (flush_i) begin
      half_q <= 1'b0;
    end else if (byte_we_i) begin
      if (!half_q) lo_q <= byte_i;
      half_q <= ~half_q;
    end
  end

  assign half_o     = half_q;
  assign word_vld_o = byte_we_i && half_q && !flush_i;
  assign word_o     = {byte_i, lo_q};
endmodule

// File: rtl/flash_tmo_timer.sv
module flash_tmo_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int              ADDR_W  = 14,
  parameter int              PG_LSB  = 9,
  parameter int              TMO_W   = 8,
  parameter logic [TMO_W-1:0] TMO_RST = 8'd100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [7:0]        reg_wdata_i,
  output logic              busy_o,
  output logic              sw_busy_o,
  output logic              failed_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fl_prog_o,
  output logic              fl_erase_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [15:0]       fl_wdata_o,
  input  logic              fl_done_i
);
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  fp_state_e         state_q;
  logic              pend_wr_q;
  logic              failed_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [WORD_W-1:0] wdata_q;

  logic idle, ctrl_we, start_erase, start_write, start;
  logic byte_we, half, word_vld, expired, addr_inc;
  logic [WORD_W-1:0] word;

  assign idle        = (state_q == ST_IDLE);
  assign ctrl_we     = reg_we_i && idle && (reg_sel_i == SEL_CTRL);
  assign start_erase = ctrl_we && reg_wdata_i[CTRL_ERASE_BIT];
  assign start_write = ctrl_we && reg_wdata_i[CTRL_WRITE_BIT];
  assign start       = start_erase || start_write;
  assign byte_we     = reg_we_i && (reg_sel_i == SEL_DATA) && (state_q == ST_COLLECT);
  assign addr_inc    = (state_q == ST_PROG) && fl_done_i;

  flash_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_lo_i (reg_we_i && idle && (reg_sel_i == SEL_ADDRL)),
    .we_hi_i (reg_we_i && idle && (reg_sel_i == SEL_ADDRH)),
    .wdata_i (reg_wdata_i),
    .inc_i   (addr_inc),
    .addr_o  (addr_o)
  );

  flash_byte_pack #(.BYTE_W(BYTE_W)) u_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (state_q != ST_COLLECT),
    .byte_we_i  (byte_we),
    .byte_i     (reg_wdata_i),
    .half_o     (half),
    .word_vld_o (word_vld),
    .word_o     (word)
  );

  flash_tmo_timer #(.TMO_W(TMO_W)) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     ((state_q == ST_COLLECT) && !word_vld),
    .limit_i   (tmo_q),
    .expired_o (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q <= TMO_RST;
    end else if (reg_we_i && idle && (reg_sel_i == SEL_TMO)) begin
      tmo_q <= reg_wdata_i[TMO_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pend_wr_q <= 1'b0;
      failed_q  <= 1'b0;
      wdata_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) failed_q <= 1'b0;
          pend_wr_q <= start_write;
          if (start_erase)      state_q <= ST_ERASE;
          else if (start_write) state_q <= ST_COLLECT;
        end
        ST_ERASE: if (fl_done_i) state_q <= pend_wr_q ? ST_COLLECT : ST_IDLE;
        ST_COLLECT: begin
          if (word_vld) begin
            wdata_q <= word;
            state_q <= ST_PROG;
          end else if (expired) begin
            failed_q <= half;  // abort only with a pair split by the gap
            state_q  <= ST_IDLE;
          end
        end
        ST_PROG: if (fl_done_i) state_q <= ST_COLLECT;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = !idle;
  assign sw_busy_o  = (state_q == ST_ERASE) || (state_q == ST_PROG);
  assign failed_o   = failed_q;
  assign fl_prog_o  = (state_q == ST_PROG);
  assign fl_erase_o = (state_q == ST_ERASE);
  assign fl_addr_o  = fl_erase_o ? {addr_o[ADDR_W-1:PG_LSB], {PG_LSB{1'b0}}} : addr_o;
  assign fl_wdata_o = wdata_q;
endmodule

// File: rtl/flash_prog_ctrl_chk.sv
module flash_prog_ctrl_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              sw_busy_o,
  input logic              failed_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              fl_prog_o,
  input logic              fl_erase_o,
  input logic              fl_done_i
);
  assert_swbusy_in_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_busy_o |-> busy_o);

  assert_one_array_op_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_prog_o && fl_erase_o));

  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_prog_o && fl_done_i) |=> (addr_o == $past(addr_o) + 1'b1));

  assert_addr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(fl_prog_o && fl_done_i)) |=> $stable(addr_o));

  assert_fail_at_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(failed_o) |-> $fell(busy_o));

  assert_erase_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_erase_o && fl_done_i) |=> !fl_erase_o);
endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .sw_busy_o  (sw_busy_o),
  .failed_o   (failed_o),
  .addr_o     (addr_o),
  .fl_prog_o  (fl_prog_o),
  .fl_erase_o (fl_erase_o),
  .fl_done_i  (fl_done_i)
);

// File: tb/flash_prog_ctrl_tb.sv
module flash_array_model #(
  parameter int ADDR_W = 14,
  parameter int PG_LSB = 9,
  parameter int LAT    = 3
) (
  input  logic              clk_i,
  input  logic              prog_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic              done_o
);
  logic [15:0] mem [int];
  bit          pg_erased [int];
  int          cnt = 0;
  byte         op_log [0:63];
  int          op_cnt = 0;

  initial done_o = 1'b0;

  function automatic logic [15:0] rd(input int a);
    if (mem.exists(a)) return mem[a];
    return pg_erased.exists(a >> PG_LSB) ? 16'hFFFF : 16'h0000;
  endfunction

  task automatic apply_op();
    int pg;
    int a;
    a = int'(addr_i);
    if (erase_i) begin
      pg = a >> PG_LSB;
      foreach (mem[k]) if ((k >> PG_LSB) == pg) mem.delete(k);
      pg_erased[pg] = 1'b1;
      if (op_cnt < 64) op_log[op_cnt] = "E";
    end else begin
      mem[a] = rd(a) & wdata_i;  // programming only clears bits
      if (op_cnt < 64) op_log[op_cnt] = "P";
    end
    op_cnt++;
  endtask

  always @(posedge clk_i) begin
    if (done_o) begin
      done_o <= 1'b0;
      cnt    <= 0;
    end else if (prog_i || erase_i) begin
      if (cnt == LAT) begin
        done_o <= 1'b1;
        apply_op();
        cnt <= 0;
      end else begin
        cnt <= cnt + 1;
      end
    end else begin
      cnt <= 0;
    end
  end
endmodule

module flash_prog_ctrl_tb;
  localparam int ADDR_W = 14;
  localparam logic [2:0] S_CTRL = 3'd0, S_AL = 3'd1, S_AH = 3'd2, S_DATA = 3'd3, S_TMO = 3'd4;
  localparam int LIMIT = 20;

  // {erase_first, addr, word, expected readback}
  localparam logic [46:0] VEC [0:5] = '{
    {1'b1, 14'h0010, 16'hA55A, 16'hA55A},
    {1'b0, 14'h0011, 16'h0FF0, 16'h0FF0},
    {1'b0, 14'h0010, 16'hFF00, 16'hA500},
    {1'b1, 14'h0010, 16'h1234, 16'h1234},
    {1'b0, 14'h3E05, 16'hBEEF, 16'h0000},
    {1'b1, 14'h3E05, 16'hBEEF, 16'hBEEF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic busy, sw_busy, failed, fl_prog, fl_erase, fl_done;
  logic [ADDR_W-1:0] addr, fl_addr;
  logic [15:0] fl_wdata;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  flash_prog_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .busy_o(busy), .sw_busy_o(sw_busy), .failed_o(failed),
    .addr_o(addr), .fl_prog_o(fl_prog), .fl_erase_o(fl_erase), .fl_addr_o(fl_addr),
    .fl_wdata_o(fl_wdata), .fl_done_i(fl_done)
  );

  flash_array_model #(.ADDR_W(ADDR_W), .PG_LSB(9), .LAT(3)) u_mem (
    .clk_i(clk), .prog_i(fl_prog), .erase_i(fl_erase), .addr_i(fl_addr),
    .wdata_i(fl_wdata), .done_o(fl_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] s, input logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_swb();
    for (int i = 0; i < 200 && sw_busy; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
  endtask

  task automatic set_addr(input logic [ADDR_W-1:0] a);
    reg_wr(S_AL, a[7:0]);
    reg_wr(S_AH, {2'b00, a[13:8]});
  endtask

  task automatic send_pair(input logic [15:0] w);
    reg_wr(S_DATA, w[7:0]);
    reg_wr(S_DATA, w[15:8]);
    chk("R5 sw_busy after pair", {31'd0, sw_busy}, 32'd1);
    wait_swb();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 sw_busy", {31'd0, sw_busy}, 32'd0);
    chk("R1 failed", {31'd0, failed}, 32'd0);
    chk("R1 addr", {18'd0, addr}, 32'd0);

    reg_wr(S_TMO, LIMIT[7:0]);

    // Table of single-word writes
    for (int v = 0; v < 6; v++) begin
      set_addr(VEC[v][45:32]);
      reg_wr(S_CTRL, VEC[v][46] ? 8'h03 : 8'h02);
      chk("R5 busy after start", {31'd0, busy}, 32'd1);
      wait_swb();
      send_pair(VEC[v][31:16]);
      wait_idle();
      chk("R3 word readback", {16'd0, u_mem.rd(int'(VEC[v][45:32]))}, {16'd0, VEC[v][15:0]});
      chk("R4 addr step", {18'd0, addr}, {18'd0, VEC[v][45:32] + 14'd1});
      chk("R9 no fail on clean end", {31'd0, failed}, 32'd0);
    end
    // erase in vector 3 also reset the neighbour word
    chk("R6 erased neighbour", {16'd0, u_mem.rd(32'h0011)}, 32'hFFFF);

    // R6 erase only, page 31
    u_mem.op_cnt = 0;
    set_addr(14'h3E40);
    reg_wr(S_CTRL, 8'h01);
    chk("R6 sw_busy during erase", {31'd0, sw_busy}, 32'd1);
    wait_idle();
    chk("R6 page ones", {16'd0, u_mem.rd(32'h3E05)}, 32'hFFFF);
    chk("R6 single op", u_mem.op_cnt, 32'd1);
    chk("R6 addr unchanged", {18'd0, addr}, 32'h3E40);

    // R7 + R4: multi-word with erase, control/address writes injected mid-stream (R2)
    u_mem.op_cnt = 0;
    set_addr(14'h0200);
    reg_wr(S_CTRL, 8'h03);
    wait_swb();
    send_pair(16'h1111);
    reg_wr(S_CTRL, 8'h01);
    reg_wr(S_AL, 8'h55);
    send_pair(16'h2222);
    send_pair(16'h3333);
    wait_idle();
    chk("R7 erase first", {24'd0, u_mem.op_log[0]}, 32'h45);
    chk("R2 ctrl ignored busy", u_mem.op_cnt, 32'd4);
    chk("R4 word n", {16'd0, u_mem.rd(32'h0200)}, 32'h1111);
    chk("R4 word n+1", {16'd0, u_mem.rd(32'h0201)}, 32'h2222);
    chk("R4 word n+2", {16'd0, u_mem.rd(32'h0202)}, 32'h3333);
    chk("R2 addr ignored busy", {18'd0, addr}, 32'h0203);

    // R8 exact window, no half pair
    set_addr(14'h0300);
    reg_wr(S_CTRL, 8'h02);
    repeat (LIMIT) @(negedge clk);
    chk("R8 busy at limit", {31'd0, busy}, 32'd1);
    @(negedge clk);
    chk("R8 busy after limit+1", {31'd0, busy}, 32'd0);
    chk("R9 clean expiry", {31'd0, failed}, 32'd0);

    // R9 half pair then gap
    set_addr(14'h0300);
    reg_wr(S_CTRL, 8'h03);
    wait_swb();
    reg_wr(S_DATA, 8'hAB);
    wait_idle();
    chk("R9 failed set", {31'd0, failed}, 32'd1);
    // R10 late byte after abort is ignored; failed stays sticky
    reg_wr(S_DATA, 8'h77);
    repeat (3) @(negedge clk);
    chk("R10 idle byte no start", {31'd0, busy}, 32'd0);
    chk("R9 sticky", {31'd0, failed}, 32'd1);

    // R9 clear on start, R10 no pairing leak
    set_addr(14'h0400);
    reg_wr(S_CTRL, 8'h03);
    chk("R9 cleared by start", {31'd0, failed}, 32'd0);
    wait_swb();
    send_pair(16'h2211);
    wait_idle();
    chk("R10 pairing intact", {16'd0, u_mem.rd(32'h0400)}, 32'h2211);

    ended = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule